// File: doc/BRIEF.md
# In-band Xon/Xoff flow controller for one serial channel

This block handles character-based flow control for a single asynchronous serial channel. On the receive path it watches every character that the deserializer delivers. It compares each one against programmable pause and resume characters. When a pause token arrives it closes a gate that stops the local transmitter, and when a resume token arrives it opens the gate again. The tokens themselves are withheld from the receive FIFO. An optional mode resumes the transmitter on any character at all. An interrupt pulse marks every recognized pause token.

On the transmit path the block watches the receive FIFO fill level against two thresholds. When the level reaches the halt threshold, it asks the serializer to insert a pause token. When the level later falls to the resume threshold, it asks for a resume token. The serializer is expected to take a pending insert ahead of the next FIFO data byte, but only once the character it is currently shifting is finished. The serializer and the FIFOs sit outside this block.

Tokens are one character long, or two consecutive characters in paired mode. The halt threshold must be programmed above the resume threshold.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: In single mode (`fc_mode`=2'b01), a received character equal to `xoff1_char` drives `tx_gate` low from the clock after the strobe. It also raises `xoff_irq` for exactly that one cycle.
- R2: In single mode, a received character equal to `xon1_char` drives `tx_gate` high again from the clock after the strobe.
- R3: In paired mode (`fc_mode`=2'b10), a pause needs `xoff1_char` with `xoff2_char` on the very next strobe, and a resume needs `xon1_char` with `xon2_char` on the next strobe. A pair broken by any other character is not recognized.
- R4: With `xon_any` high and the gate closed, any received character that does not complete a pause token reopens the gate on the next clock. This includes a resume token. A plain data character that reopens the gate is still written to the FIFO.
- R5: `rx_wr_en` equals `rx_valid`, except that it is low for the character that completes a recognized pause or resume token. In paired mode the first character of a pair is passed through.
- R6: With `fc_mode` at 2'b00 or 2'b11, no character is recognized, every character is written, and `tx_gate` is high from the next clock.
- R7: With `tx_auto_en` high and the gate state idle, a `rx_level` at or above `halt_level` raises `ins_req` on the next clock with `ins_char`=`xoff1_char`. In paired mode, the insert of `xoff2_char` follows after the first acknowledge.
- R8: A pause token is requested only once per halt crossing. After its acknowledge, `ins_req` stays low while the level stays high.
- R9: A resume token (`xon1_char`, then `xon2_char` in paired mode) is requested only after a pause token was sent, and only once `rx_level` is at or below `resume_level`.
- R10: `ins_req` stays high with `ins_char` unchanged until `ins_ack` is sampled high. An `ins_ack` pulse while no request is pending has no effect.
- R11: After reset, `tx_gate` is high and `ins_req` and `xoff_irq` are low.
- R12: A character equal to both a pause and a resume token counts as a pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_char | input | CHAR_W | Received character |
| xon1_char | input | CHAR_W | First (or only) resume character |
| xon2_char | input | CHAR_W | Second resume character for paired mode |
| xoff1_char | input | CHAR_W | First (or only) pause character |
| xoff2_char | input | CHAR_W | Second pause character for paired mode |
| fc_mode | input | 2 | 00 off, 01 single, 10 paired, 11 off |
| xon_any | input | 1 | Resume on any character while paused |
| tx_auto_en | input | 1 | Enable automatic token insertion from FIFO level |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| halt_level | input | LVL_W | Level at which a pause token is sent |
| resume_level | input | LVL_W | Level at which a resume token is sent |
| rx_wr_en | output | 1 | Write strobe toward the receive FIFO |
| tx_gate | output | 1 | High when the local transmitter may send data |
| xoff_irq | output | 1 | One-cycle pulse on a recognized pause token |
| ins_req | output | 1 | Request to insert a flow-control character |
| ins_char | output | CHAR_W | Character to insert |
| ins_ack | input | 1 | Serializer has taken the inserted character |

## Verification
Some receive-side faults show up on `tx_gate` one clock after the strobe. These include a corrupted paused flag or a pending-pair flag that was not cleared. Such a fault shows as a gate that stays closed or opens on the wrong character. A wrong discard decision shows on `rx_wr_en` in the same cycle as the strobe. On the transmit side, a wrong state in the insertion sequencer appears on `ins_req` and `ins_char` one clock after the level or acknowledge that moved it. This can be a repeated pause token, a resume token without a prior pause, or a skipped second character. The bench therefore samples each output at the one cycle where it must change.

// File: rtl/xonxoff_pkg.sv
package xonxoff_pkg;
   typedef enum logic [1:0] {
      FC_OFF    = 2'b00,
      FC_SINGLE = 2'b01,
      FC_PAIR   = 2'b10,
      FC_RSVD   = 2'b11
   } fc_mode_e;

   typedef enum logic [2:0] {
      TS_RUN     = 3'd0,
      TS_OFF_1ST = 3'd1,
      TS_OFF_2ND = 3'd2,
      TS_PAUSED  = 3'd3,
      TS_ON_1ST  = 3'd4,
      TS_ON_2ND  = 3'd5
   } tx_state_e;
endpackage

// File: rtl/xonxoff_rx_match.sv
module xonxoff_rx_match #(
   parameter int CHAR_W  = 8,
   parameter bit PAIR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic [CHAR_W-1:0] xon1_char,
   input  logic [CHAR_W-1:0] xon2_char,
   input  logic [CHAR_W-1:0] xoff1_char,
   input  logic [CHAR_W-1:0] xoff2_char,
   input  logic [1:0]        fc_mode,
   input  logic              xon_any,
   output logic              rx_wr_en,
   output logic              paused,
   output logic              xoff_irq
);
   import xonxoff_pkg::*;

   logic single_m, pair_m, active;
   logic pend_off, pend_on;
   logic hit_off, hit_on, any_resume, drop;

   assign single_m = (fc_mode == FC_SINGLE);
   assign pair_m   = PAIR_EN && (fc_mode == FC_PAIR);
   assign active   = single_m | pair_m;

   generate
      if (PAIR_EN) begin : g_pair
         logic pend_off_q, pend_on_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_off_q <= 1'b0;
               pend_on_q  <= 1'b0;
            end else if (!pair_m) begin
               pend_off_q <= 1'b0;
               pend_on_q  <= 1'b0;
            end else if (rx_valid) begin
               pend_off_q <= (rx_char == xoff1_char) && !drop;
               pend_on_q  <= (rx_char == xon1_char) && !drop;
            end
         end
         assign pend_off = pend_off_q;
         assign pend_on  = pend_on_q;
      end else begin : g_nopair
         assign pend_off = 1'b0;
         assign pend_on  = 1'b0;
      end
   endgenerate

   always_comb begin
      hit_off = 1'b0;
      hit_on  = 1'b0;
      if (single_m) begin
         hit_off = (rx_char == xoff1_char);
         hit_on  = (rx_char == xon1_char);
      end else if (pair_m) begin
         hit_off = pend_off && (rx_char == xoff2_char);
         hit_on  = pend_on && (rx_char == xon2_char);
      end
      hit_on = hit_on && !hit_off;
   end

   assign any_resume = xon_any && paused && active && !hit_off;
   assign drop       = hit_off | hit_on;
   assign rx_wr_en   = rx_valid && !drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paused   <= 1'b0;
         xoff_irq <= 1'b0;
      end else begin
         xoff_irq <= rx_valid && hit_off;
         if (!active)
            paused <= 1'b0;
         else if (rx_valid && hit_off)
            paused <= 1'b1;
         else if (rx_valid && (hit_on || any_resume))
            paused <= 1'b0;
      end
   end
endmodule

// File: rtl/xonxoff_tx_insert.sv
module xonxoff_tx_insert #(
   parameter int CHAR_W  = 8,
   parameter int LVL_W   = 7,
   parameter bit PAIR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_auto_en,
   input  logic              pair_sel,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  halt_level,
   input  logic [LVL_W-1:0]  resume_level,
   input  logic [CHAR_W-1:0] xon1_char,
   input  logic [CHAR_W-1:0] xon2_char,
   input  logic [CHAR_W-1:0] xoff1_char,
   input  logic [CHAR_W-1:0] xoff2_char,
   input  logic              ins_ack,
   output logic              ins_req,
   output logic [CHAR_W-1:0] ins_char
);
   import xonxoff_pkg::*;

   tx_state_e st_q, st_d;
   logic      two;

   assign two = PAIR_EN && pair_sel;

   always_comb begin
      st_d = st_q;
      case (st_q)
         TS_RUN:     if (tx_auto_en && rx_level >= halt_level) st_d = TS_OFF_1ST;
         TS_OFF_1ST: if (ins_ack) st_d = two ? TS_OFF_2ND : TS_PAUSED;
         TS_OFF_2ND: if (ins_ack) st_d = TS_PAUSED;
         TS_PAUSED: begin
            if (!tx_auto_en) st_d = TS_RUN;
            else if (rx_level <= resume_level) st_d = TS_ON_1ST;
         end
         TS_ON_1ST:  if (ins_ack) st_d = two ? TS_ON_2ND : TS_RUN;
         TS_ON_2ND:  if (ins_ack) st_d = TS_RUN;
         default:    st_d = TS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= TS_RUN;
      else        st_q <= st_d;
   end

   always_comb begin
      ins_req  = 1'b1;
      ins_char = '0;
      case (st_q)
         TS_OFF_1ST: ins_char = xoff1_char;
         TS_OFF_2ND: ins_char = xoff2_char;
         TS_ON_1ST:  ins_char = xon1_char;
         TS_ON_2ND:  ins_char = xon2_char;
         default:    ins_req  = 1'b0;
      endcase
   end
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
   parameter int CHAR_W  = 8,
   parameter int LVL_W   = 7,
   parameter bit PAIR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic [CHAR_W-1:0] xon1_char,
   input  logic [CHAR_W-1:0] xon2_char,
   input  logic [CHAR_W-1:0] xoff1_char,
   input  logic [CHAR_W-1:0] xoff2_char,
   input  logic [1:0]        fc_mode,
   input  logic              xon_any,
   input  logic              tx_auto_en,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  halt_level,
   input  logic [LVL_W-1:0]  resume_level,
   output logic              rx_wr_en,
   output logic              tx_gate,
   output logic              xoff_irq,
   output logic              ins_req,
   output logic [CHAR_W-1:0] ins_char,
   input  logic              ins_ack
);
   import xonxoff_pkg::*;

   generate
      if (CHAR_W < 5 || CHAR_W > 9) begin : g_bad_char_w
         $error("CHAR_W must lie between 5 and 9");
      end
      if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl_w
         $error("LVL_W must lie between 1 and 16");
      end
   endgenerate

   logic paused;

   xonxoff_rx_match #(.CHAR_W(CHAR_W), .PAIR_EN(PAIR_EN)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .xon1_char(xon1_char), .xon2_char(xon2_char),
      .xoff1_char(xoff1_char), .xoff2_char(xoff2_char),
      .fc_mode(fc_mode), .xon_any(xon_any),
      .rx_wr_en(rx_wr_en), .paused(paused), .xoff_irq(xoff_irq)
   );

   xonxoff_tx_insert #(.CHAR_W(CHAR_W), .LVL_W(LVL_W), .PAIR_EN(PAIR_EN)) u_tx (
      .clk(clk), .rst_n(rst_n), .tx_auto_en(tx_auto_en),
      .pair_sel(fc_mode == FC_PAIR),
      .rx_level(rx_level), .halt_level(halt_level), .resume_level(resume_level),
      .xon1_char(xon1_char), .xon2_char(xon2_char),
      .xoff1_char(xoff1_char), .xoff2_char(xoff2_char),
      .ins_ack(ins_ack), .ins_req(ins_req), .ins_char(ins_char)
   );

   assign tx_gate = !paused;
endmodule

// File: rtl/xonxoff_flow_ctrl_chk.sv
module xonxoff_flow_ctrl_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [CHAR_W-1:0] rx_char,
   input logic [CHAR_W-1:0] xon1_char,
   input logic [CHAR_W-1:0] xoff1_char,
   input logic [1:0]        fc_mode,
   input logic              rx_wr_en,
   input logic              tx_gate,
   input logic              xoff_irq,
   input logic              ins_req,
   input logic [CHAR_W-1:0] ins_char,
   input logic              ins_ack
);
   p_single_xoff_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && fc_mode == 2'b01 && rx_char == xoff1_char) |=> (!tx_gate && xoff_irq));

   p_irq_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      xoff_irq |-> !tx_gate);

   p_single_xon_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && fc_mode == 2'b01 && rx_char == xon1_char && rx_char != xoff1_char)
      |=> tx_gate);

   p_token_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && fc_mode == 2'b01 && (rx_char == xon1_char || rx_char == xoff1_char))
      |-> !rx_wr_en);

   p_off_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_mode == 2'b00 || fc_mode == 2'b11) |=> tx_gate);

   p_off_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_mode == 2'b00 || fc_mode == 2'b11) |-> (rx_wr_en == rx_valid));

   p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !ins_ack) |=> (ins_req && $stable(ins_char)));
endmodule

bind xonxoff_flow_ctrl xonxoff_flow_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
   .xon1_char(xon1_char), .xoff1_char(xoff1_char), .fc_mode(fc_mode),
   .rx_wr_en(rx_wr_en), .tx_gate(tx_gate), .xoff_irq(xoff_irq),
   .ins_req(ins_req), .ins_char(ins_char), .ins_ack(ins_ack)
);

// File: tb/xonxoff_flow_ctrl_tb.sv
module xonxoff_flow_ctrl_tb;
   localparam int CW = 8;
   localparam int LW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [CW-1:0] rx_char = '0;
   logic [CW-1:0] xon1 = 8'h0D, xon2 = 8'h11, xoff1 = 8'h0F, xoff2 = 8'h13;
   logic [1:0] fc_mode = 2'b01;
   logic xon_any = 1'b0, tx_auto_en = 1'b0, ins_ack = 1'b0;
   logic [LW-1:0] rx_level = 7'd5, halt_level = 7'd48, resume_level = 7'd16;
   logic rx_wr_en, tx_gate, xoff_irq, ins_req;
   logic [CW-1:0] ins_char;

   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   xonxoff_flow_ctrl #(.CHAR_W(CW), .LVL_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .xon1_char(xon1), .xon2_char(xon2), .xoff1_char(xoff1), .xoff2_char(xoff2),
      .fc_mode(fc_mode), .xon_any(xon_any), .tx_auto_en(tx_auto_en),
      .rx_level(rx_level), .halt_level(halt_level), .resume_level(resume_level),
      .rx_wr_en(rx_wr_en), .tx_gate(tx_gate), .xoff_irq(xoff_irq),
      .ins_req(ins_req), .ins_char(ins_char), .ins_ack(ins_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Send one character; check write strobe in-cycle, gate and irq next cycle.
   task automatic send(input string req, input logic [CW-1:0] c,
                       input logic ewr, input logic egate, input logic eirq);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_char  = c;
      #1 chk(req, rx_wr_en, ewr);
      @(negedge clk);
      rx_valid = 1'b0;
      chk(req, tx_gate, egate);
      chk(req, xoff_irq, eirq);
   endtask

   task automatic ack_once();
      @(negedge clk);
      ins_ack = 1'b1;
      @(negedge clk);
      ins_ack = 1'b0;
   endtask

   task automatic chk_req(input string req, input logic er, input logic [CW-1:0] ec);
      chk(req, ins_req, er);
      if (er) chk(req, ins_char, ec);
   endtask

   // Row: {mode[1:0], any, char[7:0], wr, gate, irq}
   localparam int NV = 14;
   localparam logic [13:0] VEC [NV] = '{
      {2'b01, 1'b0, 8'h41, 1'b1, 1'b1, 1'b0},  // R5 plain data
      {2'b01, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b1},  // R1
      {2'b01, 1'b0, 8'h41, 1'b1, 1'b0, 1'b0},  // R1 stays paused
      {2'b01, 1'b0, 8'h0D, 1'b0, 1'b1, 1'b0},  // R2
      {2'b01, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b1},  // R1
      {2'b01, 1'b1, 8'h42, 1'b1, 1'b1, 1'b0},  // R4 any char resumes, kept
      {2'b01, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b1},  // R1
      {2'b01, 1'b1, 8'h0D, 1'b0, 1'b1, 1'b0},  // R4 resume token itself
      {2'b00, 1'b0, 8'h0F, 1'b1, 1'b1, 1'b0},  // R6
      {2'b00, 1'b0, 8'h0D, 1'b1, 1'b1, 1'b0},  // R6
      {2'b11, 1'b0, 8'h0F, 1'b1, 1'b1, 1'b0},  // R6
      {2'b01, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b1},  // R1
      {2'b01, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b1},  // R1 repeated
      {2'b01, 1'b0, 8'h0D, 1'b0, 1'b1, 1'b0}   // R2
   };

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 gate", tx_gate, 1'b1);
      chk("R11 req", ins_req, 1'b0);
      chk("R11 irq", xoff_irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         fc_mode = VEC[i][13:12];
         xon_any = VEC[i][11];
         send("R1/R2/R4/R5/R6 table", VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end

      // R12: same character configured as pause and resume
      fc_mode = 2'b01; xon_any = 1'b0;
      xon1 = 8'h0F;
      send("R12", 8'h0F, 1'b0, 1'b0, 1'b1);
      xon1 = 8'h0D;
      send("R2", 8'h0D, 1'b0, 1'b1, 1'b0);

      // R3 paired tokens
      fc_mode = 2'b10;
      send("R3 first of pair kept R5", 8'h0F, 1'b1, 1'b1, 1'b0);
      send("R3 pair completes", 8'h13, 1'b0, 1'b0, 1'b1);
      send("R3", 8'h0D, 1'b1, 1'b0, 1'b0);
      send("R3 broken pair", 8'h41, 1'b1, 1'b0, 1'b0);
      send("R3 orphan second", 8'h11, 1'b1, 1'b0, 1'b0);
      send("R3", 8'h0D, 1'b1, 1'b0, 1'b0);
      send("R3 resume pair", 8'h11, 1'b0, 1'b1, 1'b0);

      // R4 in paired mode
      xon_any = 1'b1;
      send("R3", 8'h0F, 1'b1, 1'b1, 1'b0);
      send("R3", 8'h13, 1'b0, 1'b0, 1'b1);
      send("R4 pair-mode any", 8'h55, 1'b1, 1'b1, 1'b0);
      xon_any = 1'b0;

      // Transmit side, single mode
      fc_mode = 2'b01;
      tx_auto_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk_req("R9 no resume without pause", 1'b0, 8'h00);
      rx_level = 7'd48;
      @(negedge clk);
      chk_req("R7", 1'b1, 8'h0F);
      repeat (3) @(negedge clk);
      chk_req("R10 held", 1'b1, 8'h0F);
      ack_once();
      chk_req("R8 after ack", 1'b0, 8'h00);
      repeat (5) @(negedge clk);
      chk_req("R8 level still high", 1'b0, 8'h00);
      rx_level = 7'd20;
      @(negedge clk); @(negedge clk);
      chk_req("R9 above resume", 1'b0, 8'h00);
      rx_level = 7'd16;
      @(negedge clk);
      chk_req("R9", 1'b1, 8'h0D);
      ack_once();
      chk_req("R9 done", 1'b0, 8'h00);
      ack_once();
      chk_req("R10 stray ack", 1'b0, 8'h00);
      rx_level = 7'd60;
      @(negedge clk);
      chk_req("R10 stray ack ignored R7", 1'b1, 8'h0F);
      ack_once();

      // Paired sending
      fc_mode = 2'b10;
      rx_level = 7'd3;
      @(negedge clk);
      chk_req("R9 pair first", 1'b1, 8'h0D);
      ack_once();
      chk_req("R9 pair second", 1'b1, 8'h11);
      ack_once();
      chk_req("R9 pair done", 1'b0, 8'h00);
      rx_level = 7'd50;
      @(negedge clk);
      chk_req("R7 pair first", 1'b1, 8'h0F);
      ack_once();
      chk_req("R7 pair second", 1'b1, 8'h13);
      ack_once();
      chk_req("R8 pair done", 1'b0, 8'h00);

      // Reset while paused and requesting
      fc_mode = 2'b01;
      send("R1", 8'h0F, 1'b0, 1'b0, 1'b1);
      rx_level = 7'd2;
      @(negedge clk);
      chk_req("R9", 1'b1, 8'h0D);
      rst_n = 1'b0;
      #1;
      chk("R11 gate", tx_gate, 1'b1);
      chk("R11 req", ins_req, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule